// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block is a central barrier for a fixed number of participants. Each participant has a one-cycle arrive strobe and a level output that says whether it may proceed. When a participant arrives it flips a private sense bit. From then on it waits until one shared release flag matches that bit again. The block counts arrivals in a single counter that only it updates, so no two arrivals can race on the count. When the arrival that completes the group is counted, the counter goes back to zero and the shared flag flips. At that point every participant's sense bit equals the flag, and all of them are let go together.

The flag alternates between episodes, so the barrier can be used back to back. A participant that leaves and comes back before its peers have even seen the release flips its own sense again and waits for the next flip. It never disturbs the flag that the others are still relying on. Several arrivals in the same cycle are all counted in that cycle. An arrive strobe from a participant that is already waiting is dropped, and that participant's error output is raised for one cycle.

Top module: `sense_barrier`

## Requirements
- R1: After reset, every bit of `partGo` is 1, every bit of `protoErr` is 0, and the arrival count is 0. All sense bits and the shared flag are 0 at this point.
- R2: A participant whose `partGo` bit is 0 keeps it at 0 until an edge at which the group completes. No participant leaves before all `NUM_PARTS` have arrived in the current episode.
- R3: An arrive strobe from a participant whose `partGo` bit is 1 flips its sense bit. If that arrival does not complete the group, its `partGo` bit reads 0 from the cycle after the strobe.
- R4: All arrive strobes from proceeding participants in one cycle are counted at the same edge. A group can therefore be completed by several participants arriving together.
- R5: At the edge where the count reaches `NUM_PARTS`, the count returns to 0 and the shared flag flips. Every `partGo` bit reads 1 in the cycle after the completing strobe.
- R6: A `partGo` bit that is 1 stays 1 until that participant strobes arrive again.
- R7: A participant that arrives again after a release drops only its own `partGo` bit. It does not flip the shared flag, so peers that have not yet arrived keep reading 1.
- R8: An arrive strobe from a participant whose `partGo` bit is 0 is not counted and does not change its sense bit. The participant's `protoErr` bit reads 1 for exactly the one cycle after that strobe.
- R9: When all participants strobe arrive in the same cycle, the group completes at once and no `partGo` bit ever reads 0.
- R10: A reset in the middle of an episode drops the partial count. Every `partGo` bit reads 1 again after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| arrive | input | NUM_PARTS | Per-participant arrive strobe, one bit per participant |
| partGo | output | NUM_PARTS | Per-participant release: 1 means the participant may proceed |
| protoErr | output | NUM_PARTS | Per-participant one-cycle pulse for an arrival while still waiting |

## Verification
Both outputs respond one rising edge after a strobe. `partGo` follows the sense and flag registers directly, and `protoErr` is registered from the same edge. The bench therefore drives `arrive` on a falling edge and reads both outputs on the next falling edge, before it drives the next vector. No result is due any later than that one edge, including the release of every participant after a completing strobe. Each table row therefore holds the stimulus together with the value it must produce one edge later.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic countEn;   // at least one accepted arrival this cycle
    logic countWrap; // accepted arrivals complete the group
    logic flagFlip;  // shared release flag must invert
  } barCtrl_t;

  function automatic int unsigned cntWidth(input int unsigned parts);
    return $clog2(parts + 1);
  endfunction

endpackage

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
#(
  parameter int unsigned NUM_PARTS = 4,
  localparam int unsigned CNT_W = cntWidth(NUM_PARTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PARTS-1:0] arrive,
  input  logic [NUM_PARTS-1:0] localSense,
  input  logic                 relFlag,
  input  logic [CNT_W-1:0]     arrivedCnt,
  output logic [NUM_PARTS-1:0] acceptVec,
  output logic [CNT_W-1:0]     addAmt,
  output barCtrl_t             ctrl,
  output logic [NUM_PARTS-1:0] protoErr
);

  localparam logic [CNT_W:0] TOTAL = (CNT_W + 1)'(NUM_PARTS);

  logic [NUM_PARTS-1:0] waitingVec;
  logic [NUM_PARTS-1:0] errNext;
  logic [CNT_W:0]       sumNext;

  // A participant waits while its sense differs from the shared flag.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_PARTS; gi++) begin : g_part
      assign waitingVec[gi] = localSense[gi] ^ relFlag;
      assign acceptVec[gi]  = arrive[gi] & ~waitingVec[gi];
      assign errNext[gi]    = arrive[gi] & waitingVec[gi];
    end
  endgenerate

  // Count every accepted arrival of this cycle at once.
  always_comb begin
    addAmt = '0;
    for (int i = 0; i < NUM_PARTS; i++) begin
      addAmt = addAmt + CNT_W'(acceptVec[i]);
    end
  end

  assign sumNext = {1'b0, arrivedCnt} + {1'b0, addAmt};

  always_comb begin
    ctrl.countEn   = |acceptVec;
    ctrl.countWrap = ctrl.countEn && (sumNext == TOTAL);
    ctrl.flagFlip  = ctrl.countWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protoErr <= '0;
    end else begin
      protoErr <= errNext;
    end
  end

endmodule

// File: rtl/barrier_datapath.sv
module barrier_datapath
  import barrier_pkg::*;
#(
  parameter int unsigned NUM_PARTS = 4,
  localparam int unsigned CNT_W = cntWidth(NUM_PARTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  barCtrl_t             ctrl,
  input  logic [NUM_PARTS-1:0] acceptVec,
  input  logic [CNT_W-1:0]     addAmt,
  output logic [CNT_W-1:0]     arrivedCnt,
  output logic                 relFlag,
  output logic [NUM_PARTS-1:0] localSense,
  output logic [NUM_PARTS-1:0] partGo
);

  // Shared arrival counter, cleared when the group completes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrivedCnt <= '0;
    end else if (ctrl.countWrap) begin
      arrivedCnt <= '0;
    end else if (ctrl.countEn) begin
      arrivedCnt <= arrivedCnt + addAmt;
    end
  end

  // Shared release flag: takes the new sense of the completing arrivals.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relFlag <= 1'b0;
    end else if (ctrl.flagFlip) begin
      relFlag <= ~relFlag;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PARTS; gi++) begin : g_sense
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          localSense[gi] <= 1'b0;
        end else if (acceptVec[gi]) begin
          localSense[gi] <= ~localSense[gi];
        end
      end
      assign partGo[gi] = ~(localSense[gi] ^ relFlag);
    end
  endgenerate

endmodule

// File: rtl/sense_barrier.sv
module sense_barrier
  import barrier_pkg::*;
#(
  parameter int unsigned NUM_PARTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PARTS-1:0] arrive,
  output logic [NUM_PARTS-1:0] partGo,
  output logic [NUM_PARTS-1:0] protoErr
);

  localparam int unsigned CNT_W = cntWidth(NUM_PARTS);

  barCtrl_t             ctrl;
  logic [NUM_PARTS-1:0] acceptVec;
  logic [NUM_PARTS-1:0] localSense;
  logic [CNT_W-1:0]     addAmt;
  logic [CNT_W-1:0]     arrivedCnt;
  logic                 relFlag;

  barrier_ctrl #(.NUM_PARTS(NUM_PARTS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .arrive     (arrive),
    .localSense (localSense),
    .relFlag    (relFlag),
    .arrivedCnt (arrivedCnt),
    .acceptVec  (acceptVec),
    .addAmt     (addAmt),
    .ctrl       (ctrl),
    .protoErr   (protoErr)
  );

  barrier_datapath #(.NUM_PARTS(NUM_PARTS)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .acceptVec  (acceptVec),
    .addAmt     (addAmt),
    .arrivedCnt (arrivedCnt),
    .relFlag    (relFlag),
    .localSense (localSense),
    .partGo     (partGo)
  );

endmodule

// File: rtl/sense_barrier_chk.sv
module sense_barrier_chk
  import barrier_pkg::*;
#(
  parameter int unsigned NUM_PARTS = 4,
  localparam int unsigned CNT_W = cntWidth(NUM_PARTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PARTS-1:0] arrive,
  input logic [NUM_PARTS-1:0] partGo,
  input logic [NUM_PARTS-1:0] protoErr,
  input barCtrl_t             ctrl,
  input logic [CNT_W-1:0]     arrivedCnt
);

  // R5: the group count never reaches the total outside of a wrap.
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    arrivedCnt < CNT_W'(NUM_PARTS));

  // R5: a completion releases every participant one edge later.
  a_r5_all_go: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.countWrap |=> (&partGo));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PARTS; gi++) begin : g_chk
      // R2: a waiting participant stays held until the group completes.
      a_r2_no_early_leave: assert property (@(posedge clk) disable iff (!rstN)
        (!partGo[gi] && !ctrl.countWrap) |=> !partGo[gi]);

      // R6: a released participant stays released without a new arrival.
      a_r6_hold_go: assert property (@(posedge clk) disable iff (!rstN)
        (partGo[gi] && !arrive[gi]) |=> partGo[gi]);

      // R8: an arrival while waiting raises the error pulse.
      a_r8_err_raised: assert property (@(posedge clk) disable iff (!rstN)
        (arrive[gi] && !partGo[gi]) |=> protoErr[gi]);

      // R8: no error pulse without a waiting arrival.
      a_r8_err_only_waiting: assert property (@(posedge clk) disable iff (!rstN)
        !(arrive[gi] && !partGo[gi]) |=> !protoErr[gi]);

      // R3: an accepted arrival that does not complete the group drops go.
      a_r3_arrive_drops: assert property (@(posedge clk) disable iff (!rstN)
        (arrive[gi] && partGo[gi] && !ctrl.countWrap) |=> !partGo[gi]);
    end
  endgenerate

endmodule

bind sense_barrier sense_barrier_chk #(.NUM_PARTS(NUM_PARTS)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .arrive     (arrive),
  .partGo     (partGo),
  .protoErr   (protoErr),
  .ctrl       (ctrl),
  .arrivedCnt (arrivedCnt)
);

// File: tb/sense_barrier_tb_top.sv
`timescale 1ns/100ps
module sense_barrier_tb_top;

  localparam int unsigned NP = 4;
  localparam int NVEC = 15;

  // Each row: {arrive, expected partGo, expected protoErr} one edge later.
  localparam logic [11:0] VEC [NVEC] = '{
    {4'b0001, 4'b1110, 4'b0000}, // R3 single arrival waits
    {4'b0110, 4'b1000, 4'b0000}, // R4 two more counted together
    {4'b0000, 4'b1000, 4'b0000}, // R2 still held
    {4'b1000, 4'b1111, 4'b0000}, // R5 last arrival releases all
    {4'b0001, 4'b1110, 4'b0000}, // R7 early return, peers stay go
    {4'b0001, 4'b1110, 4'b0001}, // R8 repeat while waiting
    {4'b0000, 4'b1110, 4'b0000}, // R8 pulse lasts one cycle
    {4'b1110, 4'b1111, 4'b0000}, // R4 three together complete
    {4'b1111, 4'b1111, 4'b0000}, // R9 all at once
    {4'b0011, 4'b1100, 4'b0000}, // R3 pair arrives
    {4'b0011, 4'b1100, 4'b0011}, // R8 pair repeats, not counted
    {4'b1100, 4'b1111, 4'b0000}, // R5 completion
    {4'b0000, 4'b1111, 4'b0000}, // R6 hold go
    {4'b1010, 4'b0101, 4'b0000}, // R3 interleaved pair
    {4'b0111, 4'b1111, 4'b0010}  // R8 mixed: bit1 error, bits 0,2 complete
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] arrive = '0;
  logic [NP-1:0] partGo;
  logic [NP-1:0] protoErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sense_barrier #(.NUM_PARTS(NP)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .arrive   (arrive),
    .partGo   (partGo),
    .protoErr (protoErr)
  );

  task automatic checkOut(input string tag, input logic [NP-1:0] expGo,
                          input logic [NP-1:0] expErr);
    checks++;
    if (partGo !== expGo || protoErr !== expErr) begin
      errors++;
      $display("FAIL %s: partGo=%b protoErr=%b expected partGo=%b protoErr=%b",
               tag, partGo, protoErr, expGo, expErr);
    end
  endtask

  task automatic step(input logic [NP-1:0] a);
    @(negedge clk);
    arrive = a;
    @(negedge clk);
    arrive = '0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 reset state", 4'b1111, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset release", 4'b1111, 4'b0000);

    // Table walk: drive on a falling edge, check on the next falling edge.
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      arrive = VEC[v][11:8];
      @(negedge clk);
      arrive = '0;
      checkOut($sformatf("table row %0d", v), VEC[v][7:4], VEC[v][3:0]);
    end

    // R10: reset in the middle of an episode.
    step(4'b0001);
    checkOut("R10 partial episode", 4'b1110, 4'b0000);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R10 after mid-episode reset", 4'b1111, 4'b0000);
    // Count must restart from zero: three arrivals do not complete.
    step(4'b0111);
    checkOut("R10 count restarted", 4'b1000, 4'b0000);
    step(4'b1000);
    checkOut("R5 completion after reset", 4'b1111, 4'b0000);

    // R2: a long wait with no arrivals keeps the waiter held.
    step(4'b0100);
    for (int k = 0; k < 20; k++) @(negedge clk);
    checkOut("R2 long wait held", 4'b1011, 4'b0000);
    step(4'b1011);
    checkOut("R5 release after long wait", 4'b1111, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule